// File: doc/BRIEF.md
# Four-Pixel Region Triggered Hit Buffer

This block is the shared digital logic behind a group of four neighbouring pixels in a hybrid pixel readout chip. Each pixel hands it one discriminator line. A low-to-high transition on a line is a hit. From that edge the pixel's own counter measures how long the line stays high, giving a time-over-threshold (ToT) value. Every hit is parked in one of a few local memory slots. Each slot has its own latency countdown. When the countdown runs out, the slot checks the trigger input in that same cycle. A slot that sees no trigger is discarded at once. A slot that sees the trigger is held, and the region offers it to the column by raising a token.

The column reads the region with a request/acknowledge handshake. It gets one slot per request, oldest slot first. A slot is returned to the free pool in the cycle its data is acknowledged. Pixels whose rising edges land in the same clock cycle share one slot. A hit that finds no free slot is dropped and counted.

Pixel state machine: `PIX_LOW` and `PIX_HIGH`. `PIX_LOW` goes to `PIX_HIGH` on a high line, which is the rise. `PIX_HIGH` goes back to `PIX_LOW` on a low line, which is the fall.

Slot state machine: `SLOT_FREE`, `SLOT_WAIT` and `SLOT_HELD`.
- alloc: `SLOT_FREE` to `SLOT_WAIT`.
- expiry with trigger: `SLOT_WAIT` to `SLOT_HELD`.
- expiry without trigger: `SLOT_WAIT` to `SLOT_FREE`.
- release on acknowledge: `SLOT_HELD` to `SLOT_FREE`.

Readout state machine: `RD_IDLE`, `RD_ACK` and `RD_DROP`.
- grant: `RD_IDLE` to `RD_ACK`, when a request arrives and some slot is readable.
- `RD_ACK` lasts one cycle. It goes to `RD_DROP` if the request is still high, otherwise straight to `RD_IDLE`.
- `RD_DROP` returns to `RD_IDLE` once the request falls.

New hits take the lowest-index free slot.

Top module: `rh_region`

## Requirements
- R1: After reset, `token_o` and `read_ack_o` are low and `ovf_cnt_o` is zero.
- R2: A pixel's ToT equals the number of clock edges at which its line was sampled high, from the rise onward. The value saturates at 14. In read data, pixel p's ToT sits in `rd_tot_o[4p+3:4p]`. A pixel whose bit in the pattern is clear reads 15.
- R3: Pixels whose rises are sampled at the same edge share one slot. Bit p of `rd_pattern_o` is set exactly for pixels that hit in that slot.
- R4: If a hit's rise is sampled at edge t and the latency input is L (1 to 255, with 0 treated as 1), the trigger is sampled only at edge t+L. Trigger high at that edge keeps the hit.
- R5: A hit whose trigger is low at its expiry edge is freed without being offered. The token stays low, and the slot can take a new hit.
- R6: `token_o` is high exactly while some slot is kept and all of its pixels have finished their ToT measurement. A kept slot whose pixel is still high is not offered.
- R7: A request raised while the token is high is answered by a one-cycle `read_ack_o` at the next edge, with that slot's data. Each request returns one slot. A request with the token low gets no acknowledge.
- R8: When several slots are readable, they are returned in the order in which they were allocated, not in slot index order.
- R9: A cycle with at least one rise and no free slot drops those hits and adds one to `ovf_cnt_o`. The counter saturates at its maximum and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_i | input | NPIX | Discriminator line per pixel |
| latency_i | input | LAT_W | Trigger latency in cycles |
| trigger_i | input | 1 | Trigger, sampled at slot expiry |
| read_req_i | input | 1 | Column read request |
| token_o | output | 1 | Region has a readable hit |
| read_ack_o | output | 1 | One-cycle acknowledge with data |
| rd_pattern_o | output | NPIX | Hit pattern of the returned slot |
| rd_tot_o | output | NPIX*TOT_W | ToT per pixel of the returned slot |
| ovf_cnt_o | output | OVF_W | Saturating count of dropped-hit cycles |

## Verification
The bench keeps the default four pixels, five slots and 4-bit ToT. It narrows the overflow counter to 4 bits, so its saturation is reached within one long latency window.

With these values the bench covers several corners:
- It sweeps every pulse length from 1 to 16 on every pixel, which reaches both ToT saturation and each pixel's field position.
- It probes the trigger one cycle early, on time and one cycle late.
- It overwrites a freed low-index slot to show that age, not index, sets the readout order.

// File: rtl/rh_pkg.sv
package rh_pkg;
    typedef enum logic {PIX_LOW, PIX_HIGH} pix_state_e;
    typedef enum logic [1:0] {SLOT_FREE = 2'd0, SLOT_WAIT = 2'd1, SLOT_HELD = 2'd2} slot_state_e;
    typedef enum logic [1:0] {RD_IDLE = 2'd0, RD_ACK = 2'd1, RD_DROP = 2'd2} rd_state_e;
endpackage

// File: rtl/rh_pix_tot.sv
module rh_pix_tot
    import rh_pkg::*;
#(
    parameter int TOT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disc_i,
    output logic             rise_o,
    output logic             fall_o,
    output logic [TOT_W-1:0] tot_o
);
    localparam logic [TOT_W-1:0] TOT_SAT = {TOT_W{1'b1}} - 1'b1;

    pix_state_e       st_q, st_d;
    logic [TOT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PIX_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PIX_LOW:  if (disc_i)  st_d = PIX_HIGH;
            PIX_HIGH: if (!disc_i) st_d = PIX_LOW;
            default:  st_d = PIX_LOW;
        endcase
    end

    always_comb begin
        rise_o = (st_q == PIX_LOW) && disc_i;
        fall_o = (st_q == PIX_HIGH) && !disc_i;
        tot_o  = cnt_q;
    end

    // ToT counts sampled-high edges, saturating one below the no-hit code
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (rise_o)
            cnt_q <= TOT_W'(1);
        else if (st_q == PIX_HIGH && disc_i && cnt_q != TOT_SAT)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rh_slot.sv
module rh_slot
    import rh_pkg::*;
#(
    parameter int NPIX  = 4,
    parameter int TOT_W = 4,
    parameter int LAT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_i,
    input  logic [NPIX-1:0]       alloc_pat_i,
    input  logic [LAT_W-1:0]      lat_i,
    input  logic                  trig_i,
    input  logic [NPIX-1:0]       wr_en_i,
    input  logic [NPIX*TOT_W-1:0] wr_tot_i,
    input  logic                  release_i,
    output logic                  free_o,
    output logic                  readable_o,
    output logic [NPIX-1:0]       pat_o,
    output logic [NPIX*TOT_W-1:0] tot_o
);
    localparam logic [TOT_W-1:0] NOHIT = {TOT_W{1'b1}};

    slot_state_e           st_q, st_d;
    logic [LAT_W-1:0]      lat_q;
    logic [NPIX-1:0]       pat_q;
    logic [NPIX-1:0]       open_q;
    logic [NPIX*TOT_W-1:0] tot_q;
    logic                  expire;

    assign expire = (st_q == SLOT_WAIT) && (lat_q == LAT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SLOT_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_FREE: if (alloc_i) st_d = SLOT_WAIT;
            SLOT_WAIT: if (expire)  st_d = trig_i ? SLOT_HELD : SLOT_FREE;
            SLOT_HELD: if (release_i) st_d = SLOT_FREE;
            default:   st_d = SLOT_FREE;
        endcase
    end

    always_comb begin
        free_o     = (st_q == SLOT_FREE);
        readable_o = (st_q == SLOT_HELD) && (open_q == '0);
        pat_o      = pat_q;
        tot_o      = tot_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q  <= '0;
            pat_q  <= '0;
            open_q <= '0;
            tot_q  <= {NPIX{NOHIT}};
        end else if (st_q == SLOT_FREE) begin
            if (alloc_i) begin
                lat_q  <= (lat_i == '0) ? LAT_W'(1) : lat_i;
                pat_q  <= alloc_pat_i;
                open_q <= alloc_pat_i;
                tot_q  <= {NPIX{NOHIT}};
            end
        end else begin
            if (st_q == SLOT_WAIT && !expire)
                lat_q <= lat_q - 1'b1;
            for (int p = 0; p < NPIX; p++) begin
                if (wr_en_i[p] && open_q[p]) begin
                    tot_q[p*TOT_W +: TOT_W] <= wr_tot_i[p*TOT_W +: TOT_W];
                    open_q[p]               <= 1'b0;
                end
            end
            if (st_d == SLOT_FREE)
                open_q <= '0;
        end
    end
endmodule

// File: rtl/rh_readout.sv
module rh_readout
    import rh_pkg::*;
#(
    parameter int NSLOT = 5,
    parameter int NPIX  = 4,
    parameter int TOT_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSLOT-1:0]            readable_i,
    input  logic [NSLOT-1:0]            alloc_i,
    input  logic [NSLOT*NPIX-1:0]       slot_pat_i,
    input  logic [NSLOT*NPIX*TOT_W-1:0] slot_tot_i,
    input  logic                        read_req_i,
    output logic [NSLOT-1:0]            release_o,
    output logic                        token_o,
    output logic                        read_ack_o,
    output logic [NPIX-1:0]             rd_pat_o,
    output logic [NPIX*TOT_W-1:0]       rd_tot_o
);
    rd_state_e             st_q, st_d;
    logic [NSLOT-1:0]      older_q [NSLOT];  // older_q[i][j]: slot i allocated before slot j
    logic [NSLOT-1:0]      cand, sel_d, sel_q;
    logic [NPIX-1:0]       pat_m, pat_q;
    logic [NPIX*TOT_W-1:0] tot_m, tot_q;
    logic                  grant;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) older_q[i] <= '0;
        end else begin
            for (int k = 0; k < NSLOT; k++) begin
                if (alloc_i[k]) begin
                    for (int j = 0; j < NSLOT; j++) begin
                        if (j != k) begin
                            older_q[k][j] <= 1'b0;
                            older_q[j][k] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // A readable slot is a candidate when no other readable slot is older
    genvar gi;
    generate
        for (gi = 0; gi < NSLOT; gi++) begin : g_cand
            logic [NSLOT-1:0] col;
            always_comb begin
                for (int j = 0; j < NSLOT; j++) col[j] = older_q[j][gi];
            end
            assign cand[gi] = readable_i[gi] && !(|(col & readable_i));
        end
    endgenerate

    always_comb begin
        sel_d = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (cand[i]) sel_d = NSLOT'(1) << i;
        end
    end

    always_comb begin
        pat_m = '0;
        tot_m = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (sel_d[s]) begin
                pat_m = pat_m | slot_pat_i[s*NPIX +: NPIX];
                tot_m = tot_m | slot_tot_i[s*NPIX*TOT_W +: NPIX*TOT_W];
            end
        end
    end

    assign grant = (st_q == RD_IDLE) && read_req_i && (|readable_i);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RD_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RD_IDLE: if (grant) st_d = RD_ACK;
            RD_ACK:  st_d = read_req_i ? RD_DROP : RD_IDLE;
            RD_DROP: if (!read_req_i) st_d = RD_IDLE;
            default: st_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            pat_q <= '0;
            tot_q <= '0;
        end else if (grant) begin
            sel_q <= sel_d;
            pat_q <= pat_m;
            tot_q <= tot_m;
        end
    end

    always_comb begin
        read_ack_o = (st_q == RD_ACK);
        release_o  = (st_q == RD_ACK) ? sel_q : '0;
        token_o    = |readable_i;
        rd_pat_o   = pat_q;
        rd_tot_o   = tot_q;
    end
endmodule

// File: rtl/rh_region.sv
module rh_region
    import rh_pkg::*;
#(
    parameter int NPIX  = 4,
    parameter int NSLOT = 5,
    parameter int TOT_W = 4,
    parameter int LAT_W = 8,
    parameter int OVF_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPIX-1:0]       disc_i,
    input  logic [LAT_W-1:0]      latency_i,
    input  logic                  trigger_i,
    input  logic                  read_req_i,
    output logic                  token_o,
    output logic                  read_ack_o,
    output logic [NPIX-1:0]       rd_pattern_o,
    output logic [NPIX*TOT_W-1:0] rd_tot_o,
    output logic [OVF_W-1:0]      ovf_cnt_o
);
    localparam int SLOT_IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

    logic [NPIX-1:0]             rise, fall;
    logic [NPIX*TOT_W-1:0]       pix_tot;
    logic [SLOT_IW-1:0]          pix_slot_q [NPIX];
    logic [NSLOT-1:0]            slot_free, slot_readable, alloc_vec, release_vec;
    logic [NSLOT*NPIX-1:0]       slot_pat;
    logic [NSLOT*NPIX*TOT_W-1:0] slot_tot;
    logic [SLOT_IW-1:0]          alloc_idx;
    logic                        have_free, any_rise;
    logic [OVF_W-1:0]            ovf_q;

    genvar gp, gs;
    generate
        for (gp = 0; gp < NPIX; gp++) begin : g_pix
            rh_pix_tot #(.TOT_W(TOT_W)) u_pix (
                .clk    (clk),
                .rst_n  (rst_n),
                .disc_i (disc_i[gp]),
                .rise_o (rise[gp]),
                .fall_o (fall[gp]),
                .tot_o  (pix_tot[gp*TOT_W +: TOT_W])
            );
        end
    endgenerate

    // Lowest-index free slot takes the hit
    always_comb begin
        alloc_idx = '0;
        have_free = 1'b0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (slot_free[s]) begin
                alloc_idx = SLOT_IW'(s);
                have_free = 1'b1;
            end
        end
    end

    assign any_rise = |rise;

    always_comb begin
        alloc_vec = '0;
        if (any_rise && have_free) alloc_vec[alloc_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPIX; p++) pix_slot_q[p] <= '0;
        end else begin
            for (int p = 0; p < NPIX; p++) begin
                if (rise[p] && have_free) pix_slot_q[p] <= alloc_idx;
            end
        end
    end

    generate
        for (gs = 0; gs < NSLOT; gs++) begin : g_slot
            logic [NPIX-1:0] wr_en;
            always_comb begin
                for (int p = 0; p < NPIX; p++)
                    wr_en[p] = fall[p] && (pix_slot_q[p] == SLOT_IW'(gs));
            end
            rh_slot #(.NPIX(NPIX), .TOT_W(TOT_W), .LAT_W(LAT_W)) u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .alloc_i     (alloc_vec[gs]),
                .alloc_pat_i (rise),
                .lat_i       (latency_i),
                .trig_i      (trigger_i),
                .wr_en_i     (wr_en),
                .wr_tot_i    (pix_tot),
                .release_i   (release_vec[gs]),
                .free_o      (slot_free[gs]),
                .readable_o  (slot_readable[gs]),
                .pat_o       (slot_pat[gs*NPIX +: NPIX]),
                .tot_o       (slot_tot[gs*NPIX*TOT_W +: NPIX*TOT_W])
            );
        end
    endgenerate

    rh_readout #(.NSLOT(NSLOT), .NPIX(NPIX), .TOT_W(TOT_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .readable_i (slot_readable),
        .alloc_i    (alloc_vec),
        .slot_pat_i (slot_pat),
        .slot_tot_i (slot_tot),
        .read_req_i (read_req_i),
        .release_o  (release_vec),
        .token_o    (token_o),
        .read_ack_o (read_ack_o),
        .rd_pat_o   (rd_pattern_o),
        .rd_tot_o   (rd_tot_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= '0;
        else if (any_rise && !have_free && ovf_q != OVF_MAX)
            ovf_q <= ovf_q + 1'b1;
    end

    assign ovf_cnt_o = ovf_q;
endmodule

// File: rtl/rh_region_chk.sv
module rh_region_chk #(
    parameter int NPIX  = 4,
    parameter int TOT_W = 4,
    parameter int OVF_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  read_req_i,
    input logic                  token_o,
    input logic                  read_ack_o,
    input logic [NPIX-1:0]       rd_pattern_o,
    input logic [NPIX*TOT_W-1:0] rd_tot_o,
    input logic [OVF_W-1:0]      ovf_cnt_o
);
    localparam logic [TOT_W-1:0] NOHIT = {TOT_W{1'b1}};
    logic tot_ok;

    always_comb begin
        tot_ok = 1'b1;
        for (int p = 0; p < NPIX; p++) begin
            if (rd_pattern_o[p]) begin
                if (rd_tot_o[p*TOT_W +: TOT_W] == NOHIT || rd_tot_o[p*TOT_W +: TOT_W] == '0) tot_ok = 1'b0;
            end else if (rd_tot_o[p*TOT_W +: TOT_W] != NOHIT) begin
                tot_ok = 1'b0;
            end
        end
    end

    p_ack_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        read_ack_o |=> !read_ack_o);
    p_ack_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(read_ack_o) |-> $past(read_req_i));
    p_ack_after_token_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(read_ack_o) |-> $past(token_o));
    p_tot_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        read_ack_o |-> tot_ok);
    p_pattern_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        read_ack_o |-> (rd_pattern_o != '0));
    p_ovf_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cnt_o != $past(ovf_cnt_o)) |-> (ovf_cnt_o == $past(ovf_cnt_o) + 1'b1));
endmodule

bind rh_region rh_region_chk #(.NPIX(NPIX), .TOT_W(TOT_W), .OVF_W(OVF_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .read_req_i   (read_req_i),
    .token_o      (token_o),
    .read_ack_o   (read_ack_o),
    .rd_pattern_o (rd_pattern_o),
    .rd_tot_o     (rd_tot_o),
    .ovf_cnt_o    (ovf_cnt_o)
);

// File: tb/rh_region_tb_top.sv
module rh_region_tb_top;
    localparam int NPIX = 4, NSLOT = 5, TOT_W = 4, LAT_W = 8, OVF_W = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NPIX-1:0]       disc_r = '0;
    logic [LAT_W-1:0]      lat_r = 8'd20;
    logic                  trig_r = 1'b0;
    logic                  req_r = 1'b0;
    logic                  token, ack;
    logic [NPIX-1:0]       rpat;
    logic [NPIX*TOT_W-1:0] rtot;
    logic [OVF_W-1:0]      ovf;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rh_region #(.NPIX(NPIX), .NSLOT(NSLOT), .TOT_W(TOT_W), .LAT_W(LAT_W), .OVF_W(OVF_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .disc_i(disc_r), .latency_i(lat_r), .trigger_i(trig_r),
        .read_req_i(req_r), .token_o(token), .read_ack_o(ack), .rd_pattern_o(rpat),
        .rd_tot_o(rtot), .ovf_cnt_o(ovf)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive hits: pixel p high for len[p] cycles from cycle 0; trigger high at cycle tidx
    task automatic run_hit(input int l0, input int l1, input int l2, input int l3,
                           input int lat, input int tidx);
        int lens[4];
        int last;
        lens[0] = l0; lens[1] = l1; lens[2] = l2; lens[3] = l3;
        lat_r = LAT_W'(lat);
        last = tidx;
        for (int p = 0; p < 4; p++) if (lens[p] > last) last = lens[p];
        if (lat > last) last = lat;
        for (int i = 0; i <= last + 1; i++) begin
            for (int p = 0; p < 4; p++) disc_r[p] = (i < lens[p]);
            trig_r = (i == tidx);
            cyc(1);
        end
        disc_r = '0;
        trig_r = 1'b0;
    endtask

    task automatic read_one(output bit got, output int waitc,
                            output logic [NPIX-1:0] pat, output logic [NPIX*TOT_W-1:0] tot);
        got = 1'b0; waitc = 0; pat = '0; tot = '0;
        req_r = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            cyc(1);
            if (ack && !got) begin
                got = 1'b1; waitc = i; pat = rpat; tot = rtot;
                break;
            end
        end
        req_r = 1'b0;
        cyc(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit got;
        int w;
        logic [NPIX-1:0] pat;
        logic [NPIX*TOT_W-1:0] tot;

        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        check(token == 1'b0, "R1 token", int'(token), 0);
        check(ack == 1'b0, "R1 ack", int'(ack), 0);
        check(ovf == '0, "R1 ovf", int'(ovf), 0);

        // R2 / R4 / R7: every pixel, every pulse length 1..16, trigger on time
        for (int p = 0; p < NPIX; p++) begin
            for (int n = 1; n <= 16; n++) begin
                run_hit(p == 0 ? n : 0, p == 1 ? n : 0, p == 2 ? n : 0, p == 3 ? n : 0, 20, 20);
                check(token == 1'b1, "R4 token after kept hit", int'(token), 1);
                read_one(got, w, pat, tot);
                check(got && w == 1, "R7 ack one cycle after request", w, 1);
                check(pat == NPIX'(1 << p), "R3 single-pixel pattern", int'(pat), 1 << p);
                for (int q = 0; q < NPIX; q++) begin
                    int e;
                    e = (q == p) ? ((n > 14) ? 14 : n) : 15;
                    check(int'(tot[q*TOT_W +: TOT_W]) == e, "R2 tot field", int'(tot[q*TOT_W +: TOT_W]), e);
                end
                check(token == 1'b0, "R7 slot freed after ack", int'(token), 0);
            end
        end

        // R4 / R5: trigger one cycle early and one late are both missed
        run_hit(2, 0, 0, 0, 6, 5);
        check(token == 1'b0, "R5 early trigger drops hit", int'(token), 0);
        run_hit(0, 3, 0, 0, 6, 7);
        check(token == 1'b0, "R5 late trigger drops hit", int'(token), 0);
        read_one(got, w, pat, tot);
        check(!got, "R7 no ack without token", int'(got), 0);
        check(ovf == '0, "R5 no overflow from dropped hits", int'(ovf), 0);

        // R4: latency 1 and latency 0 (treated as 1)
        run_hit(0, 0, 4, 0, 1, 1);
        read_one(got, w, pat, tot);
        check(got && pat == 4'b0100, "R4 latency 1", int'(pat), 4);
        run_hit(0, 0, 0, 2, 0, 1);
        read_one(got, w, pat, tot);
        check(got && pat == 4'b1000, "R4 latency 0 as 1", int'(pat), 8);

        // R3: same-cycle rises share one slot, each keeps its own length
        run_hit(3, 0, 9, 0, 12, 12);
        read_one(got, w, pat, tot);
        check(got && pat == 4'b0101, "R3 shared pattern", int'(pat), 5);
        check(tot == 16'hF9F3, "R3 shared tot", int'(tot), 'hF9F3);
        read_one(got, w, pat, tot);
        check(!got, "R3 one slot only", int'(got), 0);

        // R6: kept hit with pixel still high is withheld until fall
        lat_r = 8'd3;
        for (int i = 0; i <= 9; i++) begin
            disc_r = (i < 8) ? 4'b0010 : 4'b0000;
            trig_r = (i == 3);
            cyc(1);
            if (i == 5) check(token == 1'b0, "R6 token low while measuring", int'(token), 0);
        end
        trig_r = 1'b0;
        check(token == 1'b1, "R6 token after fall", int'(token), 1);
        read_one(got, w, pat, tot);
        check(got && tot == 16'hFF8F, "R6 late tot value", int'(tot), 'hFF8F);

        // R8: freed slot 0 is reused by a younger hit; older slot 1 must come out first
        lat_r = 8'd10;
        for (int i = 0; i <= 24; i++) begin
            disc_r = '0;
            if (i == 0)  disc_r[0] = 1'b1;
            if (i == 3)  disc_r[1] = 1'b1;
            if (i == 12) disc_r[2] = 1'b1;
            trig_r = (i == 13) || (i == 22);
            cyc(1);
        end
        disc_r = '0; trig_r = 1'b0;
        read_one(got, w, pat, tot);
        check(got && pat == 4'b0010, "R8 oldest first", int'(pat), 2);
        read_one(got, w, pat, tot);
        check(got && pat == 4'b0100, "R8 younger second", int'(pat), 4);
        read_one(got, w, pat, tot);
        check(!got, "R8 nothing left", int'(got), 0);

        // R9: fill all slots, then one dropped rise per cycle until saturation
        lat_r = 8'd255;
        for (int i = 0; i < 30; i++) begin
            disc_r = '0;
            if (i < 10 && i % 2 == 0) disc_r[(i / 2) % 4] = 1'b1;
            if (i >= 10) disc_r[i % 2] = 1'b1;
            cyc(1);
            if (i == 9)  check(ovf == 4'd0, "R9 five slots accepted", int'(ovf), 0);
            if (i == 10) check(ovf == 4'd1, "R9 first drop counted", int'(ovf), 1);
            if (i == 12) check(ovf == 4'd3, "R9 count per cycle", int'(ovf), 3);
        end
        disc_r = '0;
        check(ovf == 4'd15, "R9 saturation", int'(ovf), 15);
        cyc(250);
        check(token == 1'b0, "R5 untriggered slots gone", int'(token), 0);
        check(ovf == 4'd15, "R9 sticky", int'(ovf), 15);
        run_hit(5, 5, 5, 5, 4, 4);
        check(ovf == 4'd15, "R5 slots free again", int'(ovf), 15);
        read_one(got, w, pat, tot);
        check(got && pat == 4'b1111 && tot == 16'h5555, "R5 reuse after expiry", int'(tot), 'h5555);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule